// File: doc/BRIEF.md
# Parking Bus Request Arbiter

This block is the central arbiter of a shared bus with several masters. Each slot has its own request input and its own grant output. The shared `frame` and `irdy` inputs show whether a transaction is running. The arbiter grants the bus to one requester at a time and picks among competing requesters in round-robin order. No grant moves to a different agent while the bus is busy.

When nobody is requesting, the grant is parked on a default agent. This is the host-side agent in slot `PARK_SLOT`, which is slot 0 by default. That agent can then start a transaction at once, without first raising its request. Once a granted master has started its transaction by asserting `frame`, the arbiter withdraws the grant in the next cycle. The master finishes its transaction without the grant. The arbiter waits until both `frame` and `irdy` are low, and then hands the bus to the next agent. Whenever the grant passes from one agent to another, there is a cycle in which no grant is asserted.

The controller is a four-state machine:
- ST_PARK: the grant is parked on `PARK_SLOT`.
- ST_GRANT: the grant is held by a requester.
- ST_GAP: one dead cycle with no grant.
- ST_BUSY: a transaction runs and no grant is asserted.

The named transitions are:
- park_use: ST_PARK to ST_BUSY, when the bus becomes busy.
- park_keep: ST_PARK to ST_GRANT, when the park slot itself wins.
- park_move: ST_PARK to ST_GAP, when another slot wins.
- grant_start: ST_GRANT to ST_BUSY, when the bus becomes busy.
- grant_drop: ST_GRANT to ST_GAP or ST_PARK, when the owner drops its request without starting.
- gap_done: ST_GAP to ST_GRANT or ST_PARK.
- gap_busy: ST_GAP to ST_BUSY.
- busy_end: ST_BUSY to ST_GRANT or ST_PARK, once the bus is idle.

Top module: `parking_arbiter`

## Requirements
- R1: In the first cycle after reset, `gnt` is one-hot on `PARK_SLOT` (bit 0 by default, `gnt` = 4'b0001 with four slots) and `gnt_idx` equals `PARK_SLOT`.
- R2: While the grant is on `PARK_SLOT` and no request is raised, the bus is idle and `gnt` stays on `PARK_SLOT`.
- R3: The bus is busy when `frame` or `irdy` is 1. If the bus is busy at a clock edge, `gnt` is all-zero from that edge on. This also covers the case where the parked agent starts a transaction without having requested.
- R4: When slot k, with k different from `PARK_SLOT`, requests while the grant is parked and the bus is idle, `gnt` is all-zero for one cycle and then `gnt[k]` is 1.
- R5: When several slots request at a free point, the winner is the first requesting slot after the previous owner, counting upward and wrapping from N-1 to 0.
- R6: While the bus stays busy, `gnt` stays all-zero. In the first cycle after the bus goes idle, the grant goes to the round-robin winner, or back to `PARK_SLOT` if no request is raised.
- R7: `gnt` never changes directly from one nonzero value to a different nonzero value. Between two agents there is at least one all-zero cycle.
- R8: `gnt` is always one-hot or all-zero. Whenever `gnt` is nonzero, `gnt_idx` is the index of its set bit.
- R9: A request from `PARK_SLOT` while it is parked keeps `gnt` on that slot, with no all-zero cycle.
- R10: If a granted owner drops its request without starting a transaction, the grant moves through one all-zero cycle. It goes to the next round-robin requester, or back to `PARK_SLOT` if none is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_SLOTS | Request line of each slot, active high |
| frame | input | 1 | Transaction in progress, active high |
| irdy | input | 1 | Initiator ready, active high |
| gnt | output | N_SLOTS | Grant line of each slot, one-hot or zero |
| gnt_idx | output | IDX_W | Index of the granted slot, zero when no grant |

## Verification
The bench targets the round-robin wrap from the top slot back to slot 0. A design that always searches from slot 0, or that gets the modulo wrong, would hand the bus to the wrong requester. It also holds `irdy` high after `frame` has dropped. An arbiter that watches only `frame` would then regrant in the middle of the final data phase. The bench also covers moves into and out of the parked slot, including an owner that abandons its grant. Here a design missing the dead cycle would switch grants back to back, and one that mishandles the park slot would insert a gap where none is needed.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_GRANT = 2'd1,
        ST_GAP   = 2'd2,
        ST_BUSY  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/pba_rr_pick.sv
module pba_rr_pick #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [N_SLOTS-1:0] req,
    input  logic [IDX_W-1:0]   last,
    output logic               win_vld,
    output logic [IDX_W-1:0]   win_idx
);

    // Search upward from the slot after the previous owner, wrapping around.
    always_comb begin
        int pos;
        win_vld = 1'b0;
        win_idx = '0;
        pos     = 0;
        for (int k = 1; k <= N_SLOTS; k++) begin
            pos = (int'(last) + k) % N_SLOTS;
            if (!win_vld && req[pos]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/pba_ctrl.sv
module pba_ctrl
    import pba_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int PARK_SLOT = 0,
    parameter int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] req,
    input  logic               bus_busy,
    input  logic               win_vld,
    input  logic [IDX_W-1:0]   win_idx,
    output arb_state_e         state_q,
    output logic [IDX_W-1:0]   owner_q,
    output logic [IDX_W-1:0]   last_q
);

    localparam logic [IDX_W-1:0] PARK_IDX = IDX_W'(PARK_SLOT);

    arb_state_e       state_d;
    logic [IDX_W-1:0] owner_d;
    logic [IDX_W-1:0] last_d;
    logic [IDX_W-1:0] tgt_q, tgt_d;
    logic             tpark_q, tpark_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            owner_q <= PARK_IDX;
            last_q  <= PARK_IDX;
            tgt_q   <= PARK_IDX;
            tpark_q <= 1'b1;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
            tgt_q   <= tgt_d;
            tpark_q <= tpark_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        tgt_d   = tgt_q;
        tpark_d = tpark_q;
        unique case (state_q)
            ST_PARK: begin
                if (bus_busy) begin
                    // park_use
                    state_d = ST_BUSY;
                    last_d  = PARK_IDX;
                end else if (win_vld) begin
                    if (win_idx == PARK_IDX) begin
                        // park_keep
                        state_d = ST_GRANT;
                        owner_d = PARK_IDX;
                        last_d  = PARK_IDX;
                    end else begin
                        // park_move
                        state_d = ST_GAP;
                        tgt_d   = win_idx;
                        tpark_d = 1'b0;
                    end
                end
            end
            ST_GRANT: begin
                if (bus_busy) begin
                    // grant_start
                    state_d = ST_BUSY;
                end else if (!req[owner_q]) begin
                    // grant_drop
                    if (win_vld) begin
                        state_d = ST_GAP;
                        tgt_d   = win_idx;
                        tpark_d = 1'b0;
                    end else if (owner_q == PARK_IDX) begin
                        state_d = ST_PARK;
                    end else begin
                        state_d = ST_GAP;
                        tgt_d   = PARK_IDX;
                        tpark_d = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (bus_busy) begin
                    // gap_busy
                    state_d = ST_BUSY;
                end else if (tpark_q) begin
                    // gap_done to park
                    state_d = ST_PARK;
                    owner_d = PARK_IDX;
                end else begin
                    // gap_done to grant
                    state_d = ST_GRANT;
                    owner_d = tgt_q;
                    last_d  = tgt_q;
                end
            end
            ST_BUSY: begin
                if (!bus_busy) begin
                    // busy_end
                    if (win_vld) begin
                        state_d = ST_GRANT;
                        owner_d = win_idx;
                        last_d  = win_idx;
                    end else begin
                        state_d = ST_PARK;
                        owner_d = PARK_IDX;
                    end
                end
            end
            default: state_d = ST_PARK;
        endcase
    end

endmodule

// File: rtl/pba_gnt_dec.sv
module pba_gnt_dec
    import pba_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  arb_state_e         state_q,
    input  logic [IDX_W-1:0]   owner_q,
    output logic [N_SLOTS-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx
);

    logic active;

    // Output process: only the park and grant states drive a grant line.
    always_comb begin
        active = (state_q == ST_PARK) || (state_q == ST_GRANT);
        for (int s = 0; s < N_SLOTS; s++) begin
            gnt[s] = active && (owner_q == IDX_W'(s));
        end
        gnt_idx = active ? owner_q : '0;
    end

endmodule

// File: rtl/parking_arbiter.sv
module parking_arbiter
    import pba_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int PARK_SLOT = 0,
    parameter int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] req,
    input  logic               frame,
    input  logic               irdy,
    output logic [N_SLOTS-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx
);

    arb_state_e       state_q;
    logic [IDX_W-1:0] owner_q;
    logic [IDX_W-1:0] last_q;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic             bus_busy;

    assign bus_busy = frame | irdy;

    pba_rr_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .req     (req),
        .last    (last_q),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    pba_ctrl #(.N_SLOTS(N_SLOTS), .PARK_SLOT(PARK_SLOT), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .bus_busy (bus_busy),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .state_q  (state_q),
        .owner_q  (owner_q),
        .last_q   (last_q)
    );

    pba_gnt_dec #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_dec (
        .state_q (state_q),
        .owner_q (owner_q),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int N_SLOTS   = 4,
    parameter int PARK_SLOT = 0,
    parameter int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SLOTS-1:0] req,
    input logic               frame,
    input logic               irdy,
    input logic [N_SLOTS-1:0] gnt,
    input logic [IDX_W-1:0]   gnt_idx
);

    localparam logic [N_SLOTS-1:0] PARK_VEC = N_SLOTS'(1) << PARK_SLOT;

    // R8: never more than one grant line
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R8: index names the granted line
    p_idx_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> gnt[gnt_idx]);

    // R7: no direct hand-over between two different agents
    p_dead_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && (|$past(gnt))) |-> (gnt == $past(gnt)));

    // R3 / R6: a busy bus removes every grant at the next edge
    p_busy_nogrant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame || irdy) |=> (gnt == '0));

    // R2: a parked grant stays parked while nothing happens
    p_park_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == PARK_VEC) && (req == '0) && !frame && !irdy) |=> (gnt == PARK_VEC));

endmodule

bind parking_arbiter pba_checker #(
    .N_SLOTS   (N_SLOTS),
    .PARK_SLOT (PARK_SLOT),
    .IDX_W     (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .frame   (frame),
    .irdy    (irdy),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
);

// File: tb/parking_arbiter_test.sv
module parking_arbiter_test;

    localparam int N  = 4;
    localparam int IW = 2;

    typedef struct {
        logic [N-1:0] g;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          frame = 1'b0;
    logic          irdy = 1'b0;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    parking_arbiter #(.N_SLOTS(N), .PARK_SLOT(0)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .frame   (frame),
        .irdy    (irdy),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    function automatic logic [IW-1:0] idx_of(input logic [N-1:0] g);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) if (g[i]) r = IW'(i);
        return r;
    endfunction

    task automatic check(input logic [N-1:0] exp_g, input string tag);
        n_checks++;
        if (gnt !== exp_g || gnt_idx !== idx_of(exp_g)) begin
            n_fails++;
            $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d",
                     tag, gnt, gnt_idx, exp_g, idx_of(exp_g));
        end
    endtask

    // Driver: apply inputs at negedge, push the grant expected after the next edge.
    task automatic apply(input logic [N-1:0] r, input logic f, input logic i,
                         input logic [N-1:0] exp_g, input string tag);
        exp_t e;
        req   = r;
        frame = f;
        irdy  = i;
        e.g   = exp_g;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.g, e.tag);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(4'b0001, "R1 reset park");

        apply(4'b0000, 0, 0, 4'b0001, "R2 idle park");
        apply(4'b0000, 0, 0, 4'b0001, "R2 idle park");
        // R4: slot 2 requests, gap then grant
        apply(4'b0100, 0, 0, 4'b0000, "R4 R7 gap");
        apply(4'b0100, 0, 0, 4'b0100, "R4 grant slot2");
        apply(4'b0100, 0, 0, 4'b0100, "R4 hold slot2");
        // R3: start, grant removed
        apply(4'b0000, 1, 0, 4'b0000, "R3 withdraw");
        apply(4'b1010, 1, 1, 4'b0000, "R6 busy");
        apply(4'b1010, 0, 1, 4'b0000, "R6 irdy busy");
        // R5: after owner 2, slot 3 wins over 1
        apply(4'b1010, 0, 0, 4'b1000, "R5 R6 rr slot3");
        apply(4'b1010, 1, 0, 4'b0000, "R3 withdraw");
        // R5: wrap from 3 to 0
        apply(4'b0011, 0, 0, 4'b0001, "R5 wrap slot0");
        apply(4'b0010, 1, 0, 4'b0000, "R3 withdraw");
        apply(4'b0010, 0, 0, 4'b0010, "R5 rr slot1");
        // R10: owner drops request
        apply(4'b0000, 0, 0, 4'b0000, "R10 gap to park");
        apply(4'b0000, 0, 0, 4'b0001, "R10 parked");
        // R3: parked agent starts without request
        apply(4'b0000, 1, 0, 4'b0000, "R3 park use");
        apply(4'b0000, 0, 0, 4'b0001, "R6 back to park");
        // R9: park slot requests, no gap
        apply(4'b0001, 0, 0, 4'b0001, "R9 no gap");
        apply(4'b0001, 0, 0, 4'b0001, "R9 hold");
        // R10: owner 0 drops, slot 2 requests
        apply(4'b0100, 0, 0, 4'b0000, "R10 R7 gap");
        apply(4'b0100, 0, 0, 4'b0100, "R10 grant slot2");
        apply(4'b0000, 0, 0, 4'b0000, "R10 gap to park");
        apply(4'b0000, 0, 0, 4'b0001, "R2 parked");
        apply(4'b0000, 0, 0, 4'b0001, "R2 parked");
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule